// File: doc/BRIEF.md
# Tester-Driven AHB Master Bridge

This block lets an external tester run transfers on an on-chip AHB bus through a shared test data port. While the chip runs normally, raising request pin A asks for test mode. The bridge then requests the bus from the arbiter and holds it locked. It takes ownership only on a cycle in which both grant and HREADY are high. From then on it accepts one vector at a time from the tester and turns each one into bus activity.

A vector is announced with a two-pin code in the cycle in which the acknowledge output is high. The data word for that vector follows in the next cycle. An address vector only loads the address and the transfer size. A write vector or a read vector launches one single-beat transfer. The acknowledge stays low until that transfer has finished, so the tester stretches its vector for as long as the bus stalls. After a read that ends OKAY, a drive-enable output tells the external bus interface to put the returned read data on the test port. ERROR responses are flagged back to the tester. RETRY and SPLIT make the bridge re-issue the same transfer once it owns the bus again.

Top module: `tvb_test_master`

## Requirements
- R1: After reset, hBusReq, hLock and testAck are low, and hTrans is IDLE (2'b00).
- R2: When testReqA is high in normal mode, hBusReq and hLock go high on the next cycle. testAck first rises in the cycle after a cycle in which hGrant and hReady were both high.
- R3: With testAck high, the code {testReqA,testReqB} is sampled and the vector's word is taken from testData in the following cycle. Code 2'b11 is an address vector: it loads the address and the size from testSize (0 byte, 1 halfword, 2 word) and makes no bus transfer.
- R4: Code 2'b10 (write) and code 2'b01 (read) each make exactly one transfer at the current address. hWrite is high in the address phase of a write only. The write word is held on hWdata through the whole data phase.
- R5: The first transfer after an address vector, or after entry into test mode, is NONSEQUENTIAL (2'b10). Each following transfer is SEQUENTIAL (2'b11), at the previous address plus 1 << size.
- R6: hTrans never shows BUSY (2'b01). hBurst is always 3'b001 (incrementing, unspecified length). hSize is never above 3'b010, and a testSize of 3 is issued as word.
- R7: testAck is high for exactly one cycle per vector and is low from the vector's data cycle until its transfer completes. A low hReady holds the address and the transfer type of a pending address phase unchanged.
- R8: rdDrive is high only in the acknowledge cycle that follows a read which completed with OKAY (hResp 2'b00).
- R9: A transfer that completes with ERROR (hResp 2'b01) ends the vector. testErr is high in the following acknowledge cycle, and rdDrive stays low there.
- R10: On RETRY (2'b10) or SPLIT (2'b11), hTrans goes IDLE. Once hGrant and hReady are both high, the same transfer is re-issued as NONSEQUENTIAL, and testAck stays low until the re-issued transfer completes.
- R11: Code 2'b00 leaves test mode: hBusReq and hLock go low and the bridge stays idle until testReqA is raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset |
| testReqA | input | 1 | Test entry request, high bit of the vector code |
| testReqB | input | 1 | Low bit of the vector code |
| testData | input | WIDTH | Tester word: an address or write data |
| testSize | input | 2 | Transfer size loaded with an address vector |
| testAck | output | 1 | Vector accepted, next code may be applied |
| rdDrive | output | 1 | Enables read data onto the test port |
| testErr | output | 1 | Last transfer ended with ERROR |
| hAddr | output | WIDTH | AHB address |
| hTrans | output | 2 | AHB transfer type |
| hWrite | output | 1 | AHB write direction |
| hSize | output | 3 | AHB transfer size |
| hBurst | output | 3 | AHB burst type |
| hProt | output | 4 | AHB protection attributes |
| hWdata | output | WIDTH | AHB write data |
| hReady | input | 1 | AHB transfer done |
| hResp | input | 2 | AHB response |
| hBusReq | output | 1 | Bus request to the arbiter |
| hLock | output | 1 | Locked access request |
| hGrant | input | 1 | Bus grant from the arbiter |

## Verification
The bench builds the block with the default WIDTH of 32 and the default protection value. It can therefore state full 32-bit addresses and check their byte, halfword and word increments exactly, including the odd byte address 0x2001 and the clamped size code 3. A slave model in the bench inserts wait states, gives two-cycle ERROR, RETRY and SPLIT responses, and withholds the grant both before entry and after a SPLIT. This reaches every state of the bridge, including a re-issue that has to wait for the grant.

// File: rtl/tvb_pkg.sv
package tvb_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_READY, S_VEC, S_ADDR, S_DATA, S_REWAIT
  } tvb_state_e;

  typedef struct packed {
    logic loadAddr;
    logic loadData;
    logic finish;
    logic clrSeq;
    logic markRead;
    logic markErr;
    logic clrFlags;
  } tvb_strobe_t;

  localparam logic [1:0] HT_IDLE = 2'b00;
  localparam logic [1:0] HT_NSEQ = 2'b10;
  localparam logic [1:0] HT_SEQ  = 2'b11;

  localparam logic [1:0] RSP_OKAY  = 2'b00;
  localparam logic [1:0] RSP_ERROR = 2'b01;

  localparam logic [1:0] VC_EXIT = 2'b00;
  localparam logic [1:0] VC_RD   = 2'b01;
  localparam logic [1:0] VC_WR   = 2'b10;
  localparam logic [1:0] VC_ADDR = 2'b11;
endpackage

// File: rtl/tvb_ctrl.sv
module tvb_ctrl
  import tvb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqA,
  input  logic        reqB,
  input  logic        hGrant,
  input  logic        hReady,
  input  logic [1:0]  hResp,
  input  logic        seqOk,
  output tvb_strobe_t stb,
  output logic [1:0]  hTrans,
  output logic        hWrite,
  output logic        testAck,
  output logic        busOwn
);
  tvb_state_e state, stateNxt;
  logic [1:0] codeQ;
  logic       reissue;
  logic       done;
  logic       owned;

  assign owned = hGrant & hReady;
  // a data phase ends on hReady unless the response asks for a re-issue
  assign done  = (state == S_DATA) && hReady && !hResp[1];

  always_comb begin
    stateNxt = state;
    unique case (state)
      S_IDLE:   if (reqA) stateNxt = S_REQ;
      S_REQ:    if (owned) stateNxt = S_READY;
      S_READY:  stateNxt = ({reqA, reqB} == VC_EXIT) ? S_IDLE : S_VEC;
      S_VEC:    stateNxt = (codeQ == VC_ADDR) ? S_READY : S_ADDR;
      S_ADDR:   if (hReady) stateNxt = S_DATA;
      S_DATA: begin
        if (hResp[1])    stateNxt = S_REWAIT;
        else if (hReady) stateNxt = S_READY;
      end
      S_REWAIT: if (owned) stateNxt = S_ADDR;
      default:  stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      codeQ   <= VC_EXIT;
      reissue <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == S_READY) codeQ <= {reqA, reqB};
      if (state == S_DATA && hResp[1]) reissue <= 1'b1;
      else if (done)                   reissue <= 1'b0;
    end
  end

  always_comb begin
    stb          = '0;
    stb.loadAddr = (state == S_VEC) && (codeQ == VC_ADDR);
    stb.loadData = (state == S_VEC) && (codeQ != VC_ADDR);
    stb.finish   = done;
    stb.clrSeq   = (state == S_IDLE);
    stb.markRead = done && (codeQ == VC_RD) && (hResp == RSP_OKAY);
    stb.markErr  = done && (hResp == RSP_ERROR);
    stb.clrFlags = (state == S_READY);
  end

  assign hTrans  = (state != S_ADDR) ? HT_IDLE :
                   (seqOk && !reissue) ? HT_SEQ : HT_NSEQ;
  assign hWrite  = (state == S_ADDR) && (codeQ == VC_WR);
  assign testAck = (state == S_READY);
  assign busOwn  = (state != S_IDLE);
endmodule

// File: rtl/tvb_dpath.sv
module tvb_dpath
  import tvb_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tvb_strobe_t      stb,
  input  logic [WIDTH-1:0] testData,
  input  logic [1:0]       testSize,
  output logic [WIDTH-1:0] hAddr,
  output logic [2:0]       hSize,
  output logic [WIDTH-1:0] hWdata,
  output logic             seqOk,
  output logic             rdDrive,
  output logic             testErr
);
  localparam logic [1:0] SZ_MAX = 2'b10;

  logic [WIDTH-1:0] addrReg, dataReg, stepVal;
  logic [1:0]       sizeReg, sizeIn;

  assign sizeIn  = (testSize > SZ_MAX) ? SZ_MAX : testSize;
  assign stepVal = WIDTH'(1) << sizeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      sizeReg <= SZ_MAX;
      seqOk   <= 1'b0;
      rdDrive <= 1'b0;
      testErr <= 1'b0;
    end else begin
      if (stb.loadAddr) begin
        addrReg <= testData;
        sizeReg <= sizeIn;
      end else if (stb.finish) begin
        addrReg <= addrReg + stepVal;
      end
      if (stb.loadData) dataReg <= testData;
      if (stb.loadAddr || stb.clrSeq) seqOk <= 1'b0;
      else if (stb.finish)            seqOk <= 1'b1;
      if (stb.markRead)      rdDrive <= 1'b1;
      else if (stb.clrFlags) rdDrive <= 1'b0;
      if (stb.markErr)       testErr <= 1'b1;
      else if (stb.clrFlags) testErr <= 1'b0;
    end
  end

  assign hAddr  = addrReg;
  assign hSize  = {1'b0, sizeReg};
  assign hWdata = dataReg;
endmodule

// File: rtl/tvb_test_master.sv
module tvb_test_master
  import tvb_pkg::*;
#(
  parameter int         WIDTH = 32,
  parameter logic [3:0] PROT  = 4'b0011
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             testReqA,
  input  logic             testReqB,
  input  logic [WIDTH-1:0] testData,
  input  logic [1:0]       testSize,
  output logic             testAck,
  output logic             rdDrive,
  output logic             testErr,
  output logic [WIDTH-1:0] hAddr,
  output logic [1:0]       hTrans,
  output logic             hWrite,
  output logic [2:0]       hSize,
  output logic [2:0]       hBurst,
  output logic [3:0]       hProt,
  output logic [WIDTH-1:0] hWdata,
  input  logic             hReady,
  input  logic [1:0]       hResp,
  output logic             hBusReq,
  output logic             hLock,
  input  logic             hGrant
);
  tvb_strobe_t stb;
  logic        seqOk;
  logic        busOwn;

  tvb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqA(testReqA), .reqB(testReqB),
    .hGrant(hGrant), .hReady(hReady), .hResp(hResp), .seqOk(seqOk),
    .stb(stb), .hTrans(hTrans), .hWrite(hWrite), .testAck(testAck),
    .busOwn(busOwn)
  );

  tvb_dpath #(.WIDTH(WIDTH)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .testData(testData),
    .testSize(testSize), .hAddr(hAddr), .hSize(hSize), .hWdata(hWdata),
    .seqOk(seqOk), .rdDrive(rdDrive), .testErr(testErr)
  );

  assign hBusReq = busOwn;
  assign hLock   = busOwn;
  assign hBurst  = 3'b001;
  assign hProt   = PROT;
endmodule

// File: rtl/tvb_checker.sv
module tvb_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       hTrans,
  input logic [2:0]       hSize,
  input logic             hReady,
  input logic [WIDTH-1:0] hAddr,
  input logic             testAck,
  input logic             rdDrive,
  input logic             testErr,
  input logic             hBusReq,
  input logic             hLock
);
  a_r6_no_busy: assert property (@(posedge clk) disable iff (!rstN)
    hTrans != 2'b01);

  a_r6_size_cap: assert property (@(posedge clk) disable iff (!rstN)
    hSize <= 3'b010);

  a_r7_hold_addr: assert property (@(posedge clk) disable iff (!rstN)
    (hTrans != 2'b00 && !hReady) |=> ($stable(hAddr) && $stable(hTrans)));

  a_r7_no_ack_in_xfer: assert property (@(posedge clk) disable iff (!rstN)
    (hTrans != 2'b00) |-> !testAck);

  a_r7_ack_single: assert property (@(posedge clk) disable iff (!rstN)
    testAck |=> !testAck);

  a_r8_drive_with_ack: assert property (@(posedge clk) disable iff (!rstN)
    rdDrive |-> testAck);

  a_r9_err_with_ack: assert property (@(posedge clk) disable iff (!rstN)
    testErr |-> (testAck && !rdDrive));

  a_r11_idle_unlocked: assert property (@(posedge clk) disable iff (!rstN)
    !hBusReq |-> (!hLock && hTrans == 2'b00 && !testAck));

  a_r2_req_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hBusReq) |-> !testAck);
endmodule

bind tvb_test_master tvb_checker #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rstN(rstN), .hTrans(hTrans), .hSize(hSize), .hReady(hReady),
  .hAddr(hAddr), .testAck(testAck), .rdDrive(rdDrive), .testErr(testErr),
  .hBusReq(hBusReq), .hLock(hLock)
);

// File: tb/tvb_test_master_tb_top.sv
`timescale 1ns/1ps
module tvb_test_master_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        testReqA = 1'b0, testReqB = 1'b0;
  logic [31:0] testData = '0;
  logic [1:0]  testSize = 2'd2;
  logic        testAck, rdDrive, testErr, hWrite, hBusReq, hLock;
  logic [31:0] hAddr, hWdata;
  logic [1:0]  hTrans;
  logic [2:0]  hSize, hBurst;
  logic [3:0]  hProt;
  logic        hReady = 1'b1;
  logic [1:0]  hResp = 2'b00;
  logic        hGrant = 1'b0;

  always #2.5 clk = ~clk;

  tvb_test_master dut_i (
    .clk(clk), .rstN(rstN), .testReqA(testReqA), .testReqB(testReqB),
    .testData(testData), .testSize(testSize), .testAck(testAck),
    .rdDrive(rdDrive), .testErr(testErr), .hAddr(hAddr), .hTrans(hTrans),
    .hWrite(hWrite), .hSize(hSize), .hBurst(hBurst), .hProt(hProt),
    .hWdata(hWdata), .hReady(hReady), .hResp(hResp), .hBusReq(hBusReq),
    .hLock(hLock), .hGrant(hGrant)
  );

  int total = 0, bad = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // slave and arbiter model
  int  grantOn = 0, gOff = 0;
  int  dpOn = 0, dpCnt = 0, nextWait = 0, nextResp = 0;
  logic [1:0]  sTrans = 2'b00;
  logic [31:0] sAddr = '0;
  logic        sWrite = 1'b0;
  logic [2:0]  sSize = '0;
  int unsigned qa[$], qt[$], qw[$], qs[$];
  int rdCnt = 0, errCnt = 0;

  // behavioural reference: 0 idle,1 req,2 ready,3 vec,4 addr,5 data,6 rewait
  int mode = 0, mCode = 0, mSeq = 0, mRe = 0, mRd = 0, mErr = 0;
  int unsigned mAddr = 0, mSize = 2, mWd = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mode = 0; mCode = 0; mSeq = 0; mRe = 0; mRd = 0; mErr = 0;
      mAddr = 0; mSize = 2; mWd = 0; dpOn = 0; gOff = 0;
    end else begin
      case (mode)
        0: begin mSeq = 0; if (testReqA) mode = 1; end
        1: if (hGrant && hReady) mode = 2;
        2: begin
          mRd = 0; mErr = 0;
          mCode = {testReqA, testReqB};
          mode = (mCode == 0) ? 0 : 3;
        end
        3: if (mCode == 3) begin
          mAddr = testData; mSize = (testSize == 3) ? 2 : testSize; mSeq = 0; mode = 2;
        end else begin
          mWd = testData; mode = 4;
        end
        4: if (hReady) mode = 5;
        5: if (hResp >= 2) begin
          mode = 6; mRe = 1;
        end else if (hReady) begin
          mode = 2;
          if (hResp == 0 && mCode == 1) mRd = 1;
          if (hResp == 1) mErr = 1;
          mAddr = mAddr + (1 << mSize); mSeq = 1; mRe = 0;
        end
        6: if (hGrant && hReady) mode = 4;
        default: mode = 0;
      endcase
      if (dpOn != 0) begin
        if (hReady) begin dpOn = 0; nextWait = 0; nextResp = 0; end
        else begin
          if (dpCnt == nextWait && nextResp == 3) gOff = 3;
          dpCnt++;
        end
      end else if (sTrans[1] && hReady) begin
        dpOn = 1; dpCnt = 0;
        qa.push_back(sAddr); qt.push_back(sTrans); qw.push_back(sWrite); qs.push_back(sSize);
      end
      if (gOff > 0) gOff--;
    end
  end

  always @(negedge clk) begin
    if (dpOn != 0) begin
      if (dpCnt < nextWait) begin hReady <= 1'b0; hResp <= 2'b00; end
      else if (nextResp != 0) begin
        hReady <= (dpCnt != nextWait); hResp <= 2'(nextResp);
      end else begin hReady <= 1'b1; hResp <= 2'b00; end
    end else begin hReady <= 1'b1; hResp <= 2'b00; end
    hGrant <= (grantOn != 0) && (gOff == 0);
  end

  // cycle compare against the reference
  always @(negedge clk) begin
    sTrans = hTrans; sAddr = hAddr; sWrite = hWrite; sSize = hSize;
    if (rstN) begin
      chk("R7 testAck", testAck, mode == 2);
      chk("R2 hBusReq", hBusReq, mode != 0);
      chk("R11 hLock", hLock, mode != 0);
      chk("R5 hTrans", hTrans, (mode == 4) ? ((mSeq != 0 && mRe == 0) ? 3 : 2) : 0);
      chk("R4 hWrite", hWrite, mode == 4 && mCode == 2);
      chk("R6 hBurst", hBurst, 3'b001);
      chk("R8 rdDrive", rdDrive, mRd != 0);
      chk("R9 testErr", testErr, mErr != 0);
      if (mode == 4) begin
        chk("R3 hAddr", hAddr, mAddr);
        chk("R6 hSize", hSize, mSize);
      end
      if (mode == 5 && mCode == 2) chk("R4 hWdata", hWdata, mWd);
      if (rdDrive) rdCnt++;
      if (testErr) errCnt++;
    end
  end

  task automatic vecT(input int code, input int unsigned data, input int size,
                      input int w, input int r);
    do @(negedge clk); while (!testAck);
    {testReqA, testReqB} = 2'(code);
    nextWait = w; nextResp = r;
    @(negedge clk);
    testData = data; testSize = 2'(size);
  endtask

  int expA[11] = '{32'h1000, 32'h1004, 32'h1008, 32'h2001, 32'h2002, 32'h3000,
                   32'h3004, 32'h3008, 32'h3008, 32'h300C, 32'h300C};
  int expT[11] = '{2, 3, 3, 2, 3, 2, 3, 3, 2, 3, 2};
  int expW[11] = '{1, 1, 0, 0, 1, 1, 1, 0, 0, 1, 1};
  int expS[11] = '{2, 2, 2, 0, 0, 2, 2, 2, 2, 2, 2};

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 hBusReq", hBusReq, 0);
    chk("R1 hLock", hLock, 0);
    chk("R1 testAck", testAck, 0);
    chk("R1 hTrans", hTrans, 0);
    rstN = 1'b1;
    @(negedge clk);
    testReqA = 1'b1; testReqB = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 request while waiting", hBusReq, 1);
    chk("R2 no ack before grant", testAck, 0);
    grantOn = 1;
    vecT(3, 32'h1000, 2, 0, 0);
    vecT(2, 32'hA5A50001, 0, 0, 0);
    vecT(2, 32'hA5A50002, 0, 1, 0);
    vecT(1, 0, 0, 2, 0);
    vecT(3, 32'h2001, 0, 0, 0);
    vecT(1, 0, 0, 0, 0);
    vecT(2, 32'h000000BB, 0, 0, 0);
    vecT(3, 32'h3000, 3, 0, 0);
    vecT(2, 32'h11, 0, 0, 0);
    vecT(2, 32'h22, 0, 0, 1);
    vecT(1, 0, 0, 1, 2);
    vecT(2, 32'h33, 0, 0, 3);
    vecT(0, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    chk("R11 bus released", hBusReq, 0);
    chk("R11 lock released", hLock, 0);
    chk("R11 stays idle", hTrans, 0);
    chk("R4 transfer count", qa.size(), 11);
    if (qa.size() == 11) begin
      for (int i = 0; i < 11; i++) begin
        chk("R5 address", qa[i], expA[i]);
        chk((i == 8 || i == 10) ? "R10 reissue type" : "R5 type", qt[i], expT[i]);
        chk("R4 direction", qw[i], expW[i]);
        chk("R6 size", qs[i], expS[i]);
      end
    end
    chk("R8 read drive cycles", rdCnt, 3);
    chk("R9 error cycles", errCnt, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule